// File: doc/BRIEF.md
# Two-Stage Compare Watchdog

This block guards a system against a stalled software loop. A free-running 64-bit system count is fed into the block and compared with a 64-bit compare value. Software enables the block and then has to refresh it again and again. Each refresh sets the compare value to the current count plus a programmed offset. If the count reaches the compare value, the block raises a first-stage warning. It then moves the deadline one offset further. If the count reaches that second deadline with no refresh in between, a second-stage signal is raised. That signal stays up until a refresh or a disable.

Access runs through a plain 32-bit word port. One select input picks between a control frame and a refresh frame. The control frame holds the control/status word, the offset, the compare value and an identification word. Any write to the refresh frame restarts the timeout. A version parameter fixes the offset width: version 0 gives a 32-bit offset, and version 1 gives a 48-bit offset split over two words. The identification word reports this version. The reset input is asynchronous and active-low. Its release is synchronised inside the block, so it takes effect two clock edges later.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the block is disabled. Both stage signals are clear, and the offset and compare value read as zero.
- R2: Control-frame word 7 is the identification word. Its bits [19:16] hold the VERSION parameter and bits [15:0] hold the ID_LOW parameter. All other bits read zero.
- R3: Control-frame word 2 holds offset bits [31:0]. With VERSION 1, word 3 bits [15:0] hold offset bits [47:32], and word 3 bits [31:16] read zero and ignore writes. With VERSION 0, word 3 reads zero, and writes to it do nothing at all.
- R4: When bit 0 of control word 0 is written as 1 while the block is disabled, the block is enabled. The compare value is loaded with count plus offset, and both stage signals are cleared.
- R5: While enabled with stage one clear, a count at or above the compare value sets stage one. The same edge reloads the compare value with count plus offset.
- R6: While enabled with stage one set, a count at or above the compare value sets stage two. Stage two stays set until a refresh or a disable.
- R7: A write to any word of the refresh frame (frame select 1) is a refresh while enabled. A refresh loads the compare value with count plus offset and clears both stages. While disabled, the same write has no effect.
- R8: While enabled, a write to an offset word stores the new offset and also acts as a refresh using the new offset.
- R9: Writing bit 0 of control word 0 as 0 disables the block and clears both stages. While disabled, no stage is ever set.
- R10: Control word 0 reads enable at bit 0, stage one at bit 1 and stage two at bit 2. Writes to bits 1 and 2 are ignored. Writing 1 to bit 0 while already enabled is not a refresh.
- R11: Control-frame words 4 and 5 read and write compare bits [31:0] and [63:32] directly.
- R12: The outputs stage1_o and stage2_o follow the stage-one and stage-two bits in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_cnt | input | 64 | Free-running system count |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | Write when 1 |
| bus_frame | input | 1 | 0 selects the control frame, 1 selects the refresh frame |
| bus_addr | input | 3 | Word index inside the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| stage1_o | output | 1 | First-stage expiry |
| stage2_o | output | 1 | Second-stage expiry |

## Verification
The bench lets the count run into the compare value twice. A design that did not reload after the first expiry would raise both stages together, or stage two far too late. It refreshes through both the refresh frame and an offset write, and then refreshes while disabled. A block that refreshed while disabled would change the compare value. A block that missed the offset-write refresh would leave stage one standing. It rewrites the enable bit while already enabled and writes the read-only stage bits. A design that treated either as a refresh or as writable would shift the deadline or show false stages. The bench also programs a 48-bit offset whose sum carries into the compare high word. It writes the reserved upper half of the high offset word and compares against a version-0 instance. Truncating to 32 bits, or storing reserved bits, shows up in the readback.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned HI_W   = 16;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_OFFS_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_OFFS_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 3'd5;
  localparam logic [ADDR_W-1:0] A_IDENT   = 3'd7;

  localparam int unsigned CTRL_EN  = 0;
  localparam int unsigned CTRL_WS0 = 1;
  localparam int unsigned CTRL_WS1 = 2;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int unsigned VERSION = 1,
  parameter logic [15:0] ID_LOW  = 16'h5D01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cmp_q,
  input  logic              ws0_q,
  input  logic              ws1_q,
  output logic              en_q,
  output logic [CNT_W-1:0]  offs_ext,
  output logic              restart,
  output logic              kill,
  output logic              cmp_wr_lo,
  output logic              cmp_wr_hi
);
  localparam bit HAS_HI = (VERSION != 0);
  localparam logic [3:0] VER4 = 4'(VERSION);

  logic              wr_ctl, wr_ref;
  logic              en_d, lo_wr, hi_wr;
  logic [WORD_W-1:0] offs_lo_q, lo_next;
  logic [HI_W-1:0]   offs_hi, hi_next;

  assign wr_ctl = bus_en & bus_we & ~bus_frame;
  assign wr_ref = bus_en & bus_we & bus_frame;
  assign lo_wr  = wr_ctl & (bus_addr == A_OFFS_LO);
  assign hi_wr  = wr_ctl & (bus_addr == A_OFFS_HI) & HAS_HI;

  // next-state for enable and refresh decode
  always_comb begin
    en_d      = en_q;
    restart   = 1'b0;
    kill      = 1'b0;
    cmp_wr_lo = 1'b0;
    cmp_wr_hi = 1'b0;
    if (wr_ctl) begin
      case (bus_addr)
        A_CTRL: begin
          en_d    = bus_wdata[CTRL_EN];
          kill    = ~bus_wdata[CTRL_EN];
          restart = bus_wdata[CTRL_EN] & ~en_q;
        end
        A_OFFS_LO: restart = en_q;
        A_OFFS_HI: restart = en_q & HAS_HI;
        A_CMP_LO:  cmp_wr_lo = 1'b1;
        A_CMP_HI:  cmp_wr_hi = 1'b1;
        default:   ;
      endcase
    end
    if (wr_ref && en_q) restart = 1'b1;
  end

  assign lo_next  = lo_wr ? bus_wdata : offs_lo_q;
  assign hi_next  = hi_wr ? bus_wdata[HI_W-1:0] : offs_hi;
  assign offs_ext = CNT_W'({hi_next, lo_next});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      offs_lo_q <= '0;
    end else begin
      en_q <= en_d;
      if (lo_wr) offs_lo_q <= bus_wdata;
    end
  end

  generate
    if (HAS_HI) begin : g_wide
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_q <= '0;
        else if (hi_wr) hi_q <= bus_wdata[HI_W-1:0];
      end
      assign offs_hi = hi_q;
    end else begin : g_narrow
      assign offs_hi = '0;
    end
  endgenerate

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (!bus_frame) begin
      case (bus_addr)
        A_CTRL:    bus_rdata = {29'b0, ws1_q, ws0_q, en_q};
        A_OFFS_LO: bus_rdata = offs_lo_q;
        A_OFFS_HI: bus_rdata = {16'b0, offs_hi};
        A_CMP_LO:  bus_rdata = cmp_q[WORD_W-1:0];
        A_CMP_HI:  bus_rdata = cmp_q[CNT_W-1:WORD_W];
        A_IDENT:   bus_rdata = {12'b0, VER4, ID_LOW};
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_stage_timer.sv
module wdt_stage_timer
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_q,
  input  logic [CNT_W-1:0]  sys_cnt,
  input  logic [CNT_W-1:0]  offs_ext,
  input  logic              restart,
  input  logic              kill,
  input  logic              cmp_wr_lo,
  input  logic              cmp_wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              ws0_q,
  output logic              ws1_q
);
  logic [CNT_W-1:0] cmp_d, reload;
  logic             ws0_d, ws1_d, hit;

  assign reload = sys_cnt + offs_ext;
  assign hit    = (sys_cnt >= cmp_q);

  always_comb begin
    cmp_d = cmp_q;
    ws0_d = ws0_q;
    ws1_d = ws1_q;
    if (kill) begin
      ws0_d = 1'b0;
      ws1_d = 1'b0;
    end else if (restart) begin
      cmp_d = reload;
      ws0_d = 1'b0;
      ws1_d = 1'b0;
    end else if (cmp_wr_lo) begin
      cmp_d[WORD_W-1:0] = wdata;
    end else if (cmp_wr_hi) begin
      cmp_d[CNT_W-1:WORD_W] = wdata;
    end else if (en_q && hit) begin
      if (!ws0_q) begin
        ws0_d = 1'b1;
        cmp_d = reload;
      end else begin
        ws1_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      ws0_q <= 1'b0;
      ws1_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      ws0_q <= ws0_d;
      ws1_q <= ws1_d;
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int unsigned VERSION = 1,
  parameter logic [15:0] ID_LOW  = 16'h5D01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] sys_cnt,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic        bus_frame,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        stage1_o,
  output logic        stage2_o
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             en_q, restart, kill, cmp_wr_lo, cmp_wr_hi;
  logic             ws0_q, ws1_q;
  logic [CNT_W-1:0] offs_ext, cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  wdt_regfile #(.VERSION(VERSION), .ID_LOW(ID_LOW)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_frame(bus_frame),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_q(cmp_q), .ws0_q(ws0_q), .ws1_q(ws1_q),
    .en_q(en_q), .offs_ext(offs_ext), .restart(restart), .kill(kill),
    .cmp_wr_lo(cmp_wr_lo), .cmp_wr_hi(cmp_wr_hi)
  );

  wdt_stage_timer u_timer (
    .clk(clk), .rst_n(rst_int_n), .en_q(en_q), .sys_cnt(sys_cnt),
    .offs_ext(offs_ext), .restart(restart), .kill(kill),
    .cmp_wr_lo(cmp_wr_lo), .cmp_wr_hi(cmp_wr_hi), .wdata(bus_wdata),
    .cmp_q(cmp_q), .ws0_q(ws0_q), .ws1_q(ws1_q)
  );

  assign stage1_o = ws0_q;
  assign stage2_o = ws1_q;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int unsigned VERSION = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en_q,
  input logic        ws0_q,
  input logic        ws1_q,
  input logic        restart,
  input logic        kill,
  input logic        bus_frame,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_rdata
);
  AST_STAGE2_AFTER_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
    ws1_q |-> ws0_q);  // R6
  AST_STAGE2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ws1_q && !restart && !kill) |=> ws1_q);  // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!ws0_q && !ws1_q));  // R9
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!en_q && !ws0_q && !ws1_q));  // R9
  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (en_q && !ws0_q && !ws1_q));  // R7
  AST_HI_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_frame && bus_addr == 3'd3) |-> (bus_rdata[31:16] == 16'h0));  // R3
  AST_VERSION_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_frame && bus_addr == 3'd7) |-> (bus_rdata[19:16] == 4'(VERSION)));  // R2
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .en_q(en_q), .ws0_q(ws0_q), .ws1_q(ws1_q),
  .restart(restart), .kill(kill), .bus_frame(bus_frame),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDL = 16'h5D01;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cnt;
  logic        b_en, b_we, b_frame;
  logic [2:0]  b_addr;
  logic [31:0] b_wdata, rdata1, rdata0;
  logic        st1, st2, st1_v0, st2_v0;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_two_stage #(.VERSION(1), .ID_LOW(IDL)) dut (
    .clk(clk), .rst_n(rst_n), .sys_cnt(cnt), .bus_en(b_en), .bus_we(b_we),
    .bus_frame(b_frame), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_rdata(rdata1), .stage1_o(st1), .stage2_o(st2));

  wdt_two_stage #(.VERSION(0), .ID_LOW(IDL)) dut_v0 (
    .clk(clk), .rst_n(rst_n), .sys_cnt(cnt), .bus_en(b_en), .bus_we(b_we),
    .bus_frame(b_frame), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_rdata(rdata0), .stage1_o(st1_v0), .stage2_o(st2_v0));

  // behavioural reference for the version-1 instance
  logic        m_en, m_ws0, m_ws1, rs, kl, wl, wh, en_next;
  logic [47:0] m_offs, n_offs;
  logic [63:0] m_cmp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ws0 = 0; m_ws1 = 0; m_offs = '0; m_cmp = '0;
    end else begin
      rs = 0; kl = 0; wl = 0; wh = 0; n_offs = m_offs; en_next = m_en;
      if (b_en && b_we && !b_frame) begin
        case (b_addr)
          3'd0: begin en_next = b_wdata[0]; kl = !b_wdata[0]; rs = b_wdata[0] && !m_en; end
          3'd2: begin n_offs[31:0] = b_wdata; rs = m_en; end
          3'd3: begin n_offs[47:32] = b_wdata[15:0]; rs = m_en; end
          3'd4: wl = 1;
          3'd5: wh = 1;
          default: ;
        endcase
      end
      if (b_en && b_we && b_frame && m_en) rs = 1;
      if (kl) begin m_ws0 = 0; m_ws1 = 0; end
      else if (rs) begin m_cmp = cnt + {16'h0, n_offs}; m_ws0 = 0; m_ws1 = 0; end
      else if (wl) m_cmp[31:0] = b_wdata;
      else if (wh) m_cmp[63:32] = b_wdata;
      else if (m_en && cnt >= m_cmp) begin
        if (!m_ws0) begin m_ws0 = 1; m_cmp = cnt + {16'h0, n_offs}; end
        else m_ws1 = 1;
      end
      m_en = en_next;
      m_offs = n_offs;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {29'b0, m_ws1, m_ws0, m_en};
      3'd2: return m_offs[31:0];
      3'd3: return {16'b0, m_offs[47:32]};
      3'd4: return m_cmp[31:0];
      3'd5: return m_cmp[63:32];
      3'd7: return {12'b0, 4'd1, IDL};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // count advances between edges; per-cycle stage comparison
  always @(negedge clk) begin
    cnt = cnt + 64'd1;
    if (rst_n) begin
      cyc++;
      chk({62'b0, st2, st1}, {62'b0, m_ws1, m_ws0}, "R12 stage outputs vs model");
      if (cyc > 150000) begin
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic wr(input logic fr, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    b_en = 1; b_we = 1; b_frame = fr; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_en = 0; b_we = 0; b_frame = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    @(negedge clk);
    b_addr = a; b_frame = 0;
    #1;
    chk({32'b0, rdata1}, {32'b0, exp_rd(a)}, tag);
  endtask

  task automatic rd_lit(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    b_addr = a; b_frame = 0;
    #1;
    chk({32'b0, rdata1}, {32'b0, e}, tag);
  endtask

  task automatic rd_v0(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    b_addr = a; b_frame = 0;
    #1;
    chk({32'b0, rdata0}, {32'b0, e}, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; cnt = 64'h0000_0000_FFFF_FF40;
    b_en = 0; b_we = 0; b_frame = 0; b_addr = '0; b_wdata = '0;
    idle(3);
    rst_n = 1;
    idle(4);

    // R1 reset state
    rd_lit(3'd0, 32'h0, "R1 ctrl after reset");
    rd_lit(3'd2, 32'h0, "R1 offset lo after reset");
    rd_lit(3'd3, 32'h0, "R1 offset hi after reset");
    rd_lit(3'd4, 32'h0, "R1 compare lo after reset");
    rd_lit(3'd5, 32'h0, "R1 compare hi after reset");
    // R2 identification
    rd_lit(3'd7, {12'h0, 4'd1, IDL}, "R2 ident v1");
    rd_v0(3'd7, {12'h0, 4'd0, IDL}, "R2 ident v0");

    // R3 offset layout and reserved bits
    wr(0, 3'd3, 32'hABCD_0012);
    rd_lit(3'd3, 32'h0000_0012, "R3 hi offset reserved half");
    rd_v0(3'd3, 32'h0, "R3 v0 hi offset reads zero");
    wr(0, 3'd2, 32'h0000_0030);
    rd_lit(3'd2, 32'h0000_0030, "R3 lo offset");
    rd_v0(3'd2, 32'h0000_0030, "R3 v0 lo offset");
    wr(0, 3'd3, 32'h0);

    // R9 disabled: no expiry though count exceeds compare
    idle(80);
    rd_lit(3'd0, 32'h0, "R9 disabled no stage");

    // R4 enable
    wr(0, 3'd0, 32'h1);
    rd(3'd4, "R4 compare lo on enable");
    rd(3'd5, "R4 compare hi on enable");
    rd_lit(3'd0, 32'h1, "R4 enabled ctrl");

    // R5 first stage, R6 second stage
    idle(50);
    rd_lit(3'd0, 32'h3, "R5 first stage set");
    rd(3'd4, "R5 compare reloaded");
    idle(50);
    rd_lit(3'd0, 32'h7, "R6 second stage set");
    idle(30);
    rd_lit(3'd0, 32'h7, "R6 second stage sticky");

    // R7 refresh frame
    wr(1, 3'd0, 32'h0);
    rd_lit(3'd0, 32'h1, "R7 refresh clears stages");
    for (int i = 0; i < 8; i++) begin
      idle(20);
      wr(1, 3'd5, 32'h0);
    end
    rd_lit(3'd0, 32'h1, "R7 periodic refresh keeps stages clear");

    // R10 rewrite enable and stage bits
    wr(0, 3'd0, 32'h7);
    rd_lit(3'd0, 32'h1, "R10 stage bits read-only");
    rd(3'd4, "R10 re-enable is not a refresh");

    // R8 offset write refreshes
    idle(55);
    rd_lit(3'd0, 32'h3, "R8 first stage before offset write");
    wr(0, 3'd2, 32'h0000_0040);
    rd_lit(3'd0, 32'h1, "R8 offset write clears stage");
    rd(3'd4, "R8 compare from new offset");

    // R11 direct compare write
    wr(0, 3'd5, cnt[63:32]);
    wr(0, 3'd4, cnt[31:0] + 32'd10);
    rd(3'd4, "R11 compare lo written");
    rd(3'd5, "R11 compare hi written");
    idle(14);
    rd_lit(3'd0, 32'h3, "R11 early expiry from written compare");

    // R9 disable clears; R7 refresh while disabled ignored
    wr(0, 3'd0, 32'h0);
    rd_lit(3'd0, 32'h0, "R9 disable clears stages");
    wr(1, 3'd0, 32'h0);
    rd(3'd4, "R7 refresh while disabled ignored");
    idle(100);
    rd_lit(3'd0, 32'h0, "R9 still idle");

    // R3 wide offset carries into compare high word
    wr(0, 3'd3, 32'h0000_0001);
    wr(0, 3'd2, 32'h0000_0010);
    wr(0, 3'd0, 32'h1);
    rd(3'd5, "R3 48-bit offset into compare hi");
    rd(3'd4, "R3 48-bit offset into compare lo");
    rd_v0(3'd3, 32'h0, "R3 v0 hi still zero");

    idle(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule